// File: doc/BRIEF.md
# Pipelined Banked Memory with Registered Fanout and Return Trees

This block is a large on-chip memory made of many small, independent storage groups. A single requester reaches it through one read/write port and may issue one request every clock. No request is ever refused. The address, write data and write strobe do not drive all groups from one point. They pass through three levels of registered distribution nodes that branch 2, 4 and 5 ways. Each branch has its own private copy of every driven register, so no register feeds more than one subtree. Only the selected subtree sees an asserted enable.

Read data comes back through a registered collection tree with the same three levels. Every read therefore completes after the same fixed number of clocks, whichever group holds the word. A separate valid pipeline marks the cycle in which each read result appears.

Group count per level, words per group and data width are parameters. The defaults are 40 groups of 32 words of 32 bits.

Top module: `banked_mem_top`

## Requirements
- R1: While `rst` is high at a clock edge, the pipelines are cleared. After reset, `rd_valid` is low, `rd_data` is zero and no group is enabled until a request arrives.
- R2: The 11-bit address has four fields. Bit 10 is the first-level branch s0 (0..1). Bits 9:8 are the second-level branch s1 (0..3). Bits 7:5 are the third-level branch s2 (0..4). Bits 4:0 are the word within the group. The group number is (s0*4+s1)*5+s2. A read returns the last value written to the same group and word.
- R3: An in-range request enables exactly one group, 3 clock edges after it is accepted. A write therefore changes only its own word in its own group; the same word offset in every other group keeps its value.
- R4: An address with s2 in 5..7 is out of range. A write to such an address changes no stored word. A read of such an address still produces `rd_valid` at the normal time, with `rd_data` equal to zero.
- R5: Suppose a read (`req_en`=1, `req_we`=0) is sampled on clock edge t. Then `rd_valid` is high and `rd_data` holds its result from edge t+6 until edge t+7. This is 7 register stages in total: 3 forward, 1 RAM access and 3 return.
- R6: `rd_valid` is high only in the cycles named by R5. Writes and idle cycles never produce `rd_valid`.
- R7: A new request may be sampled on every edge with no stall. Results come out in issue order, one per read.
- R8: A read issued on the edge right after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_en | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read (when `req_en` is high) |
| req_addr | input | 11 | Word address, fields as in R2 |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read result present on `rd_data` |
| rd_data | output | 32 | Read result; zero for an out-of-range read |

## Verification
The bench records, for every rising edge, what the port should show once that edge's request has crossed all 7 register stages. It then compares `rd_valid` and `rd_data` on the falling edge six clock edges after the edge that sampled the request. This covers writes and idle cycles as well as reads, so a valid pulse that is missing, early, late or spurious is caught in the exact cycle where it happens. Group enables are checked 3 edges after acceptance, against the address decode. Read-after-write results come from a reference array that is updated in issue order.

// File: rtl/bm_pkg.sv
package bm_pkg;

  // Number of branching levels in the request and return trees.
  localparam int TREE_LEVELS = 3;

  // Bits needed to pick one of `fan` branches (at least one).
  function automatic int sel_width(input int fan);
    return (fan <= 1) ? 1 : $clog2(fan);
  endfunction

endpackage

// File: rtl/bm_fanout_stage.sv
// One registered distribution node. Every branch gets its own copy of the
// request registers; only the branch named by the top address field is enabled.
module bm_fanout_stage #(
  parameter int FAN    = 2,
  parameter int SEL_W  = 1,
  parameter int AW_IN  = 8,
  parameter int DW     = 32,
  localparam int AW_OUT = AW_IN - SEL_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_en,
  input  logic                        in_we,
  input  logic [AW_IN-1:0]            in_addr,
  input  logic [DW-1:0]               in_wdata,
  output logic [FAN-1:0]              out_en,
  output logic [FAN-1:0]              out_we,
  output logic [FAN-1:0][AW_OUT-1:0]  out_addr,
  output logic [FAN-1:0][DW-1:0]      out_wdata
);

  logic [SEL_W-1:0] sel;
  assign sel = in_addr[AW_IN-1 -: SEL_W];

  for (genvar i = 0; i < FAN; i++) begin : g_branch
    // Enable copy: reset, and asserted only for the chosen branch.
    always_ff @(posedge clk) begin
      if (rst) out_en[i] <= 1'b0;
      else     out_en[i] <= in_en && (sel == SEL_W'(i));
    end

    // Payload copies: no reset, one private register set per branch.
    always_ff @(posedge clk) begin
      out_we[i]    <= in_we;
      out_addr[i]  <= in_addr[AW_OUT-1:0];
      out_wdata[i] <= in_wdata;
    end
  end

endmodule

// File: rtl/bm_bank.sv
// One storage group: synchronous single-port RAM with a registered read.
module bm_bank #(
  parameter int AW = 5,
  parameter int DW = 32,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          hit,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we)  mem[addr] <= wdata;
    if (en && !we) rdata     <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) hit <= 1'b0;
    else     hit <= en && !we;
  end

endmodule

// File: rtl/bm_collect_stage.sv
// One registered collection node: merges FAN returns, of which at most one
// carries a hit, into a single registered result. No hit gives zero data.
module bm_collect_stage #(
  parameter int FAN = 2,
  parameter int DW  = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [FAN-1:0]         in_hit,
  input  logic [FAN-1:0][DW-1:0] in_data,
  output logic                   out_hit,
  output logic [DW-1:0]          out_data
);

  logic [DW-1:0] merged;

  always_comb begin
    merged = '0;
    for (int i = 0; i < FAN; i++) begin
      if (in_hit[i]) merged = merged | in_data[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_hit  <= 1'b0;
      out_data <= '0;
    end else begin
      out_hit  <= |in_hit;
      out_data <= merged;
    end
  end

endmodule

// File: rtl/banked_mem_top.sv
module banked_mem_top
  import bm_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int GROUP_AW = 5,
  parameter int FAN0     = 2,
  parameter int FAN1     = 4,
  parameter int FAN2     = 5,
  localparam int SEL0_W  = sel_width(FAN0),
  localparam int SEL1_W  = sel_width(FAN1),
  localparam int SEL2_W  = sel_width(FAN2),
  localparam int ADDR_W  = SEL0_W + SEL1_W + SEL2_W + GROUP_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_en,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  localparam int AW1    = ADDR_W - SEL0_W;
  localparam int AW2    = AW1 - SEL1_W;
  localparam int NODES2 = FAN0 * FAN1;
  localparam int NLEAF  = NODES2 * FAN2;
  localparam int LAT    = 2 * TREE_LEVELS + 1;

  // Forward tree, level 1 and 2 outputs, then leaf inputs.
  logic [FAN0-1:0]               l1_en, l1_we;
  logic [FAN0-1:0][AW1-1:0]      l1_addr;
  logic [FAN0-1:0][DATA_W-1:0]   l1_wdata;
  logic [NODES2-1:0]             l2_en, l2_we;
  logic [NODES2-1:0][AW2-1:0]    l2_addr;
  logic [NODES2-1:0][DATA_W-1:0] l2_wdata;
  logic [NLEAF-1:0]              leaf_en, leaf_we;
  logic [NLEAF-1:0][GROUP_AW-1:0] leaf_addr;
  logic [NLEAF-1:0][DATA_W-1:0]  leaf_wdata;

  // Return tree.
  logic [NLEAF-1:0]              leaf_hit;
  logic [NLEAF-1:0][DATA_W-1:0]  leaf_rdata;
  logic [NODES2-1:0]             c2_hit;
  logic [NODES2-1:0][DATA_W-1:0] c2_data;
  logic [FAN0-1:0]               c1_hit;
  logic [FAN0-1:0][DATA_W-1:0]   c1_data;
  logic                          top_hit;

  // ---------------- request fanout ----------------
  bm_fanout_stage #(.FAN(FAN0), .SEL_W(SEL0_W), .AW_IN(ADDR_W), .DW(DATA_W)) u_fan0 (
    .clk(clk), .rst(rst),
    .in_en(req_en), .in_we(req_we), .in_addr(req_addr), .in_wdata(req_wdata),
    .out_en(l1_en), .out_we(l1_we), .out_addr(l1_addr), .out_wdata(l1_wdata)
  );

  for (genvar j = 0; j < FAN0; j++) begin : g_fan1
    bm_fanout_stage #(.FAN(FAN1), .SEL_W(SEL1_W), .AW_IN(AW1), .DW(DATA_W)) u_node (
      .clk(clk), .rst(rst),
      .in_en(l1_en[j]), .in_we(l1_we[j]), .in_addr(l1_addr[j]), .in_wdata(l1_wdata[j]),
      .out_en(l2_en[j*FAN1 +: FAN1]), .out_we(l2_we[j*FAN1 +: FAN1]),
      .out_addr(l2_addr[j*FAN1 +: FAN1]), .out_wdata(l2_wdata[j*FAN1 +: FAN1])
    );
  end

  for (genvar n = 0; n < NODES2; n++) begin : g_fan2
    bm_fanout_stage #(.FAN(FAN2), .SEL_W(SEL2_W), .AW_IN(AW2), .DW(DATA_W)) u_node (
      .clk(clk), .rst(rst),
      .in_en(l2_en[n]), .in_we(l2_we[n]), .in_addr(l2_addr[n]), .in_wdata(l2_wdata[n]),
      .out_en(leaf_en[n*FAN2 +: FAN2]), .out_we(leaf_we[n*FAN2 +: FAN2]),
      .out_addr(leaf_addr[n*FAN2 +: FAN2]), .out_wdata(leaf_wdata[n*FAN2 +: FAN2])
    );
  end

  // ---------------- storage groups ----------------
  for (genvar g = 0; g < NLEAF; g++) begin : g_bank
    bm_bank #(.AW(GROUP_AW), .DW(DATA_W)) u_bank (
      .clk(clk), .rst(rst),
      .en(leaf_en[g]), .we(leaf_we[g]), .addr(leaf_addr[g]), .wdata(leaf_wdata[g]),
      .hit(leaf_hit[g]), .rdata(leaf_rdata[g])
    );
  end

  // ---------------- return collection ----------------
  for (genvar n = 0; n < NODES2; n++) begin : g_col2
    bm_collect_stage #(.FAN(FAN2), .DW(DATA_W)) u_node (
      .clk(clk), .rst(rst),
      .in_hit(leaf_hit[n*FAN2 +: FAN2]), .in_data(leaf_rdata[n*FAN2 +: FAN2]),
      .out_hit(c2_hit[n]), .out_data(c2_data[n])
    );
  end

  for (genvar j = 0; j < FAN0; j++) begin : g_col1
    bm_collect_stage #(.FAN(FAN1), .DW(DATA_W)) u_node (
      .clk(clk), .rst(rst),
      .in_hit(c2_hit[j*FAN1 +: FAN1]), .in_data(c2_data[j*FAN1 +: FAN1]),
      .out_hit(c1_hit[j]), .out_data(c1_data[j])
    );
  end

  bm_collect_stage #(.FAN(FAN0), .DW(DATA_W)) u_col0 (
    .clk(clk), .rst(rst),
    .in_hit(c1_hit), .in_data(c1_data),
    .out_hit(top_hit), .out_data(rd_data)
  );

  // ---------------- read-valid pipeline ----------------
  // Runs beside the trees so that dropped reads are still marked.
  logic [LAT-1:0] vpipe;

  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[LAT-2:0], req_en && !req_we};
  end

  assign rd_valid = vpipe[LAT-1];

endmodule

// File: rtl/bm_checker.sv
module bm_checker #(
  parameter int GROUP_AW = 5,
  parameter int FAN0     = 2,
  parameter int FAN1     = 4,
  parameter int FAN2     = 5,
  parameter int SEL0_W   = 1,
  parameter int SEL1_W   = 2,
  parameter int SEL2_W   = 3,
  parameter int ADDR_W   = 11,
  parameter int NLEAF    = 40
) (
  input logic              clk,
  input logic              rst,
  input logic              req_en,
  input logic              req_we,
  input logic [ADDR_W-1:0] req_addr,
  input logic [NLEAF-1:0]  leaf_en,
  input logic              top_hit,
  input logic              rd_valid
);

  logic [SEL0_W-1:0] f0;
  logic [SEL1_W-1:0] f1;
  logic [SEL2_W-1:0] f2;
  logic              in_range;

  assign f0 = req_addr[ADDR_W-1 -: SEL0_W];
  assign f1 = req_addr[ADDR_W-SEL0_W-1 -: SEL1_W];
  assign f2 = req_addr[GROUP_AW +: SEL2_W];
  assign in_range = (int'(f0) < FAN0) && (int'(f1) < FAN1) && (int'(f2) < FAN2);

  // Cycles since reset, saturating; guards the 7-deep look-back.
  logic [3:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= '0;
    else if (since_rst < 4'd8) since_rst <= since_rst + 4'd1;
  end

  // R1: one edge of reset leaves the pipelines empty.
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!rd_valid && (leaf_en == '0)));

  // R3: an in-range request reaches exactly one group three edges later.
  p_one_group_r3: assert property (@(posedge clk) disable iff (rst)
    (req_en && in_range) |-> ##3 ($countones(leaf_en) == 1));

  // R3: never more than one group enabled.
  p_group_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(leaf_en));

  // R4: an out-of-range request enables no group.
  p_drop_oor_r4: assert property (@(posedge clk) disable iff (rst)
    (req_en && !in_range) |-> ##3 (leaf_en == '0));

  // R5: valid appears exactly after the 7-stage pipeline.
  p_valid_latency_r5: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 4'd7) |-> (rd_valid == $past(req_en && !req_we, 7)));

  // R6: a write never yields a valid result.
  p_write_silent_r6: assert property (@(posedge clk) disable iff (rst)
    (req_en && req_we) |-> ##7 !rd_valid);

  // R4: returned data from a group only ever accompanies a valid read.
  p_hit_has_valid_r4: assert property (@(posedge clk) disable iff (rst)
    top_hit |-> rd_valid);

endmodule

bind banked_mem_top bm_checker #(
  .GROUP_AW(GROUP_AW), .FAN0(FAN0), .FAN1(FAN1), .FAN2(FAN2),
  .SEL0_W(SEL0_W), .SEL1_W(SEL1_W), .SEL2_W(SEL2_W),
  .ADDR_W(ADDR_W), .NLEAF(NLEAF)
) u_chk (
  .clk(clk), .rst(rst), .req_en(req_en), .req_we(req_we), .req_addr(req_addr),
  .leaf_en(leaf_en), .top_hit(top_hit), .rd_valid(rd_valid)
);

// File: tb/banked_mem_top_tb.sv
module banked_mem_top_tb;

  localparam int DW     = 32;
  localparam int AW     = 11;
  localparam int WORDS  = 32;
  localparam int NGRP   = 40;
  localparam int DEPTHQ = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_en = 1'b0;
  logic          req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rd_valid;
  logic [DW-1:0] rd_data;

  banked_mem_top u_dut (
    .clk(clk), .rst(rst), .req_en(req_en), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always #10 clk = ~clk;  // 50 MHz

  int unsigned tests = 0;
  int unsigned fails = 0;
  int unsigned npos  = 0;
  bit          mon_on = 1'b0;

  logic [DW-1:0] ref_mem [NGRP*WORDS];
  bit            exp_v   [DEPTHQ];
  logic [DW-1:0] exp_d   [DEPTHQ];
  string         exp_tag [DEPTHQ];

  always @(posedge clk) npos <= npos + 1;

  function automatic logic [AW-1:0] mk_addr(int s0, int s1, int s2, int w);
    return {1'(s0), 2'(s1), 3'(s2), 5'(w)};
  endfunction

  function automatic bit in_range(logic [AW-1:0] a);
    return a[7:5] < 3'd5;
  endfunction

  function automatic int ref_idx(logic [AW-1:0] a);
    return ((int'(a[10]) * 4 + int'(a[9:8])) * 5 + int'(a[7:5])) * WORDS + int'(a[4:0]);
  endfunction

  // One request (or idle) per call; records what the port shows 6 edges on.
  task automatic op(input bit en, input bit we, input logic [AW-1:0] a,
                    input logic [DW-1:0] d, input string tag);
    int s;
    @(negedge clk);
    #1;
    s = int'((npos + 1) % DEPTHQ);
    req_en = en; req_we = we; req_addr = a; req_wdata = d;
    exp_tag[s] = tag;
    if (en && !we) begin
      exp_v[s] = 1'b1;
      exp_d[s] = in_range(a) ? ref_mem[ref_idx(a)] : '0;
    end else begin
      exp_v[s] = 1'b0;
      exp_d[s] = '0;
      if (en && we && in_range(a)) ref_mem[ref_idx(a)] = d;
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    op(1'b1, 1'b1, a, d, "R6");
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    op(1'b1, 1'b0, a, '0, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(1'b0, 1'b0, '0, '0, "R6");
  endtask

  // Per-cycle monitor: result of the request sampled 6 edges earlier.
  always @(negedge clk) begin
    if (mon_on) begin
      int s;
      s = int'((npos - 6) % DEPTHQ);
      tests++;
      if (rd_valid !== exp_v[s]) begin
        fails++;
        $display("FAIL %s rd_valid got %b expected %b at edge %0d", exp_tag[s], rd_valid, exp_v[s], npos);
      end else if (exp_v[s]) begin
        tests++;
        if (rd_data !== exp_d[s]) begin
          fails++;
          $display("FAIL %s rd_data got %h expected %h at edge %0d", exp_tag[s], rd_data, exp_d[s], npos);
        end
      end
    end
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTHQ; i++) begin
      exp_v[i] = 1'b0; exp_d[i] = '0; exp_tag[i] = "R6";
    end
    repeat (10) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: quiet outputs after reset
    tests++;
    if (rd_valid !== 1'b0 || rd_data !== '0) begin
      fails++;
      $display("FAIL R1 after reset got valid=%b data=%h expected 0/0", rd_valid, rd_data);
    end
    mon_on = 1'b1;

    // R2 / R6: fill every in-range word with an address-derived pattern.
    for (int g0 = 0; g0 < 2; g0++)
      for (int g1 = 0; g1 < 4; g1++)
        for (int g2 = 0; g2 < 5; g2++)
          for (int w = 0; w < WORDS; w++) begin
            a = mk_addr(g0, g1, g2, w);
            wr(a, 32'h5A000000 ^ (32'(ref_idx(a)) * 32'h9E3779B1));
          end
    // R2: read the whole map back, back to back.
    for (int g0 = 0; g0 < 2; g0++)
      for (int g1 = 0; g1 < 4; g1++)
        for (int g2 = 0; g2 < 5; g2++)
          for (int w = 0; w < WORDS; w++)
            rd(mk_addr(g0, g1, g2, w), "R2");
    idle(8);

    // R5: isolated reads surrounded by idle cycles.
    rd(mk_addr(0, 0, 0, 0), "R5");
    idle(9);
    rd(mk_addr(1, 3, 4, 31), "R5");
    idle(9);

    // R3: one word offset written in one group; same offset elsewhere intact.
    wr(mk_addr(1, 2, 3, 7), 32'hC0FFEE01);
    for (int g0 = 0; g0 < 2; g0++)
      for (int g1 = 0; g1 < 4; g1++)
        for (int g2 = 0; g2 < 5; g2++)
          rd(mk_addr(g0, g1, g2, 7), "R3");
    idle(8);

    // R4: out-of-range writes change nothing; reads of them return zero.
    for (int s2 = 5; s2 < 8; s2++) wr(mk_addr(0, 1, s2, 3), 32'hDEADBEEF);
    for (int s2 = 5; s2 < 8; s2++) rd(mk_addr(0, 1, s2, 3), "R4");
    for (int s2 = 0; s2 < 5; s2++) rd(mk_addr(0, 1, s2, 3), "R4");
    idle(8);

    // R8: read right after a write to the same address.
    wr(mk_addr(0, 2, 1, 9), 32'h11112222);
    rd(mk_addr(0, 2, 1, 9), "R8");
    wr(mk_addr(0, 2, 1, 9), 32'h33334444);
    rd(mk_addr(0, 2, 1, 9), "R8");
    wr(mk_addr(1, 0, 4, 0), 32'h55556666);
    rd(mk_addr(1, 0, 4, 0), "R8");
    rd(mk_addr(0, 2, 1, 9), "R8");
    idle(8);

    // R7: constrained random mix, one request per cycle with idle gaps.
    for (int i = 0; i < 3000; i++) begin
      int kind;
      kind = int'($urandom % 8);
      a = mk_addr(int'($urandom % 2), int'($urandom % 4), int'($urandom % 8), int'($urandom % 32));
      if (kind == 0)      idle(1);
      else if (kind < 4)  wr(a, $urandom);
      else                rd(a, "R7");
    end
    idle(10);

    mon_on = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule